// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This controller decides which low-power stop state a microcontroller enters when the CPU reports that it has just executed a stop instruction. In that same cycle it samples five configuration inputs: a stop permit, a debug permit, a supply-monitor enable, a supply-monitor-in-stop enable and a partial-power-down select. From them it chooses one of three outcomes. It may issue a one-cycle illegal-opcode reset request. It may enter one of three light stop variants: debug (clocks kept running), regulator-held, or plain. Or it may enter the deep stop state.

While in a stop state it drives the clock gate, the domain power-down enable, the regulator keep-alive and the I/O hold latch enable. A light stop is left on any interrupt input or on the external wake request, and run mode is back after one clock. The deep stop ignores both of these. It is left only through the active-low wake pin, which is first passed through a configurable synchronizer. The controller then holds a wake reset for a fixed number of cycles. The I/O hold latch stays closed until that reset ends.

Top module: `stop_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (run). `reg_keep_o` is 1. `clk_gate_o`, `pwr_down_o`, `io_hold_o`, `wake_rst_o` and `ill_rst_o` are all 0.
- R2: If `stop_exec_i` is high in run mode while `cfg_stop_en_i` is 0, `ill_rst_o` goes high for exactly the following cycle and `mode_o` stays 0.
- R3: With stop permitted and `cfg_dbg_en_i` = 1, the next cycle shows `mode_o` = 1, `clk_gate_o` = 0 and `reg_keep_o` = 1, whatever the three remaining bits are.
- R4: With stop permitted, debug off, and both supply-monitor bits 1, the next cycle shows `mode_o` = 2, `clk_gate_o` = 1, `reg_keep_o` = 1 and `pwr_down_o` = 0.
- R5: With stop permitted, debug off, at least one supply-monitor bit 0 and `cfg_ppd_i` = 0, the next cycle shows `mode_o` = 3, `clk_gate_o` = 1, `reg_keep_o` = 0 and `pwr_down_o` = 0.
- R6: With stop permitted, debug off, at least one supply-monitor bit 0 and `cfg_ppd_i` = 1, the next cycle shows `mode_o` = 4, with `clk_gate_o`, `pwr_down_o` and `io_hold_o` all 1 and `reg_keep_o` = 0.
- R7: The configuration inputs are sampled only in the cycle where `stop_exec_i` is high. Changing them at any other time does not change `mode_o`.
- R8: In modes 1 to 3, any bit of `irq_i` or `ext_wake_i` set high returns `mode_o` to 0, with `clk_gate_o` = 0, one clock later.
- R9: In mode 4, `irq_i`, `ext_wake_i` and `stop_exec_i` have no effect. A low level on `wake_pin_n_i` held before clock edge k gives `mode_o` = 5 after edge k+SYNC_STAGES.
- R10: Mode 5 lasts WAKE_RST_CYC cycles, with `wake_rst_o` = 1 and `io_hold_o` = 1 throughout. After that, `mode_o` = 0 and `wake_rst_o` and `io_hold_o` both drop in the same cycle.
- R11: `stop_exec_i` is ignored in every stop mode (1 to 5). It causes neither a mode change nor an `ill_rst_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_exec_i | input | 1 | One-cycle strobe: CPU executed a stop instruction |
| cfg_stop_en_i | input | 1 | Stop permitted |
| cfg_dbg_en_i | input | 1 | Debug permitted (keeps clocks in stop) |
| cfg_lvd_en_i | input | 1 | Supply monitor enable |
| cfg_lvd_stop_en_i | input | 1 | Supply monitor kept in stop |
| cfg_ppd_i | input | 1 | Partial power-down select |
| irq_i | input | N_IRQ | Interrupt inputs, active high |
| ext_wake_i | input | 1 | External reset wake request, active high |
| wake_pin_n_i | input | 1 | Asynchronous wake pin, active low |
| mode_o | output | 3 | 0 run, 1 debug stop, 2 regulator stop, 3 plain stop, 4 deep stop, 5 wake reset |
| clk_gate_o | output | 1 | Core clocks gated off |
| pwr_down_o | output | 1 | Logic domain powered down |
| reg_keep_o | output | 1 | Voltage regulator kept in full regulation |
| io_hold_o | output | 1 | I/O control latch closed |
| wake_rst_o | output | 1 | Wake reset after deep stop |
| ill_rst_o | output | 1 | Illegal-opcode reset request pulse |

## Verification
All outputs are decoded from the state register, so a stop strobe or a light-mode wake applied before a rising edge shows up just after that edge. The bench drives every input on the falling edge and reads the outputs on the next falling edge. A low wake pin goes through SYNC_STAGES flops before the state register sees it, so the bench checks that `mode_o` still reads 4 for exactly SYNC_STAGES falling edges and reads 5 on the next one. It then expects WAKE_RST_CYC samples of mode 5 before run mode returns. The illegal request is read on the falling edge after the strobe and read again one cycle later, to show that it lasts only one cycle.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_LS_DBG   = 3'd1,
      ST_LS_REG   = 3'd2,
      ST_LS_PLAIN = 3'd3,
      ST_DEEP     = 3'd4,
      ST_WAKE_RST = 3'd5
   } mode_e;

   typedef struct packed {
      logic stop_en;
      logic dbg_en;
      logic lvd_en;
      logic lvd_stop_en;
      logic ppd;
   } cfg_t;

   typedef struct packed {
      logic clk_gate;
      logic pwr_down;
      logic reg_keep;
      logic io_hold;
      logic wake_rst;
   } ctl_t;

   function automatic logic is_light(input mode_e m);
      return (m == ST_LS_DBG) || (m == ST_LS_REG) || (m == ST_LS_PLAIN);
   endfunction

endpackage

// File: rtl/stopctl_select.sv
module stopctl_select
   import stopctl_pkg::*;
(
   input  cfg_t  cfg_i,
   output logic  illegal_o,
   output mode_e target_o
);

   logic lvd_both;

   assign lvd_both = cfg_i.lvd_en & cfg_i.lvd_stop_en;

   always_comb begin
      illegal_o = 1'b0;
      target_o  = ST_RUN;
      if (!cfg_i.stop_en) begin
         illegal_o = 1'b1;
      end else if (cfg_i.dbg_en) begin
         target_o = ST_LS_DBG;
      end else if (lvd_both) begin
         target_o = ST_LS_REG;
      end else if (cfg_i.ppd) begin
         target_o = ST_DEEP;
      end else begin
         target_o = ST_LS_PLAIN;
      end
   end

   always_comb begin
      if (illegal_o) begin
         a_ill_run_r2 : assert (target_o == ST_RUN);
      end
   end

endmodule

// File: rtl/stopctl_pin_sync.sv
module stopctl_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_i,
   output logic pin_n_o
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("stopctl_pin_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign pin_n_o = pin_n_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else if (STAGES == 1) sh_q <= pin_n_i;
            else sh_q <= {sh_q[STAGES-2+(STAGES==1):0], pin_n_i};
         end
         assign pin_n_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/stopctl_wake_timer.sv
module stopctl_wake_timer #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o
);

   localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

   generate
      if (CYC < 1) begin : g_bad
         $error("stopctl_wake_timer: CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= CW'(CYC - 1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   p_cnt_down_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/stopctl_outdec.sv
module stopctl_outdec
   import stopctl_pkg::*;
(
   input  mode_e mode_i,
   output ctl_t  ctl_o
);

   always_comb begin
      ctl_o = '0;
      unique case (mode_i)
         ST_RUN:      ctl_o.reg_keep = 1'b1;
         ST_LS_DBG:   ctl_o.reg_keep = 1'b1;
         ST_LS_REG: begin
            ctl_o.clk_gate = 1'b1;
            ctl_o.reg_keep = 1'b1;
         end
         ST_LS_PLAIN: ctl_o.clk_gate = 1'b1;
         ST_DEEP: begin
            ctl_o.clk_gate = 1'b1;
            ctl_o.pwr_down = 1'b1;
            ctl_o.io_hold  = 1'b1;
         end
         ST_WAKE_RST: begin
            ctl_o.reg_keep = 1'b1;
            ctl_o.io_hold  = 1'b1;
            ctl_o.wake_rst = 1'b1;
         end
         default: ctl_o.reg_keep = 1'b1;
      endcase
   end

endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
   import stopctl_pkg::*;
#(
   parameter int N_IRQ       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int WAKE_RST_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_exec_i,
   input  logic             cfg_stop_en_i,
   input  logic             cfg_dbg_en_i,
   input  logic             cfg_lvd_en_i,
   input  logic             cfg_lvd_stop_en_i,
   input  logic             cfg_ppd_i,
   input  logic [N_IRQ-1:0] irq_i,
   input  logic             ext_wake_i,
   input  logic             wake_pin_n_i,
   output logic [2:0]       mode_o,
   output logic             clk_gate_o,
   output logic             pwr_down_o,
   output logic             reg_keep_o,
   output logic             io_hold_o,
   output logic             wake_rst_o,
   output logic             ill_rst_o
);

   generate
      if (N_IRQ < 1) begin : g_bad_irq
         $error("stop_mode_ctrl: N_IRQ must be at least 1");
      end
   endgenerate

   mode_e st_q, st_d;
   cfg_t  cfg;
   mode_e target;
   logic  sel_illegal;
   logic  ill_q, ill_d;
   logic  pin_n_sync;
   logic  tmr_load, tmr_done;
   logic  wake_any;
   ctl_t  ctl;

   assign cfg = '{stop_en: cfg_stop_en_i, dbg_en: cfg_dbg_en_i,
                  lvd_en: cfg_lvd_en_i, lvd_stop_en: cfg_lvd_stop_en_i,
                  ppd: cfg_ppd_i};
   assign wake_any = (|irq_i) | ext_wake_i;

   stopctl_select u_sel (
      .cfg_i     (cfg),
      .illegal_o (sel_illegal),
      .target_o  (target)
   );

   stopctl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n_i (wake_pin_n_i),
      .pin_n_o (pin_n_sync)
   );

   stopctl_wake_timer #(.CYC(WAKE_RST_CYC)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .done_o (tmr_done)
   );

   always_comb begin
      st_d     = st_q;
      ill_d    = 1'b0;
      tmr_load = 1'b0;
      unique case (st_q)
         ST_RUN: begin
            if (stop_exec_i) begin
               if (sel_illegal) ill_d = 1'b1;
               else             st_d  = target;
            end
         end
         ST_LS_DBG, ST_LS_REG, ST_LS_PLAIN: begin
            if (wake_any) st_d = ST_RUN;
         end
         ST_DEEP: begin
            if (!pin_n_sync) begin
               st_d     = ST_WAKE_RST;
               tmr_load = 1'b1;
            end
         end
         ST_WAKE_RST: begin
            if (tmr_done) st_d = ST_RUN;
         end
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_RUN;
         ill_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         ill_q <= ill_d;
      end
   end

   stopctl_outdec u_dec (
      .mode_i (st_q),
      .ctl_o  (ctl)
   );

   assign mode_o     = st_q;
   assign clk_gate_o = ctl.clk_gate;
   assign pwr_down_o = ctl.pwr_down;
   assign reg_keep_o = ctl.reg_keep;
   assign io_hold_o  = ctl.io_hold;
   assign wake_rst_o = ctl.wake_rst;
   assign ill_rst_o  = ill_q;

   p_ill_pulse_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      ill_rst_o |=> !ill_rst_o);

   p_ill_stay_run_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && stop_exec_i && !cfg_stop_en_i) |=> (ill_rst_o && mode_o == 3'd0));

   p_dbg_clocks_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd1) |-> (!clk_gate_o && reg_keep_o));

   p_deep_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4) |-> (io_hold_o && pwr_down_o && clk_gate_o));

   p_run_hold_cfg_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && !stop_exec_i) |=> (mode_o == 3'd0));

   p_light_exit_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (is_light(st_q) && wake_any) |=> (mode_o == 3'd0 && !clk_gate_o));

   p_deep_pin_only_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DEEP && pin_n_sync) |=> (mode_o == 3'd4));

   p_hold_release_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(io_hold_o) |-> (mode_o == 3'd0 && $past(wake_rst_o)));

   p_stop_ignored_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_RUN && stop_exec_i) |=> !ill_rst_o);

endmodule

// File: tb/sim_stop_mode_ctrl.sv
module sim_stop_mode_ctrl;

   localparam int NIRQ = 4;
   localparam int SYNC = 2;
   localparam int WRC  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_exec = 1'b0;
   logic c_stop = 1'b0, c_dbg = 1'b0, c_lvd = 1'b0, c_lvds = 1'b0, c_ppd = 1'b0;
   logic [NIRQ-1:0] irq = '0;
   logic ext_wake = 1'b0;
   logic pin_n = 1'b1;
   logic [2:0] mode;
   logic clk_gate, pwr_down, reg_keep, io_hold, wake_rst, ill_rst;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   stop_mode_ctrl #(.N_IRQ(NIRQ), .SYNC_STAGES(SYNC), .WAKE_RST_CYC(WRC)) u0 (
      .clk(clk), .rst_n(rst_n), .stop_exec_i(stop_exec),
      .cfg_stop_en_i(c_stop), .cfg_dbg_en_i(c_dbg), .cfg_lvd_en_i(c_lvd),
      .cfg_lvd_stop_en_i(c_lvds), .cfg_ppd_i(c_ppd), .irq_i(irq),
      .ext_wake_i(ext_wake), .wake_pin_n_i(pin_n), .mode_o(mode),
      .clk_gate_o(clk_gate), .pwr_down_o(pwr_down), .reg_keep_o(reg_keep),
      .io_hold_o(io_hold), .wake_rst_o(wake_rst), .ill_rst_o(ill_rst)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_cfg(input logic [4:0] v);
      {c_stop, c_dbg, c_lvd, c_lvds, c_ppd} = v;
   endtask

   // Pulse stop_exec for one cycle with config v; return at the falling edge after.
   task automatic do_stop(input logic [4:0] v);
      @(negedge clk);
      set_cfg(v);
      stop_exec = 1'b1;
      @(negedge clk);
      stop_exec = 1'b0;
   endtask

   task automatic wake_light();
      @(negedge clk);
      ext_wake = 1'b1;
      @(negedge clk);
      ext_wake = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 mode", mode, 0);
      check("R1 reg_keep", reg_keep, 1);
      check("R1 others", {clk_gate, pwr_down, io_hold, wake_rst, ill_rst}, 0);
   endtask

   task automatic t_illegal();
      do_stop(5'b01111);
      check("R2 ill pulse", ill_rst, 1);
      check("R2 mode run", mode, 0);
      @(negedge clk);
      check("R2 ill one cycle", ill_rst, 0);
   endtask

   task automatic t_dbg();
      do_stop(5'b11111);
      check("R3 mode", mode, 1);
      check("R3 clocks on", clk_gate, 0);
      check("R3 reg_keep", reg_keep, 1);
      wake_light();
      do_stop(5'b11000);
      check("R3 mode other bits", mode, 1);
      wake_light();
   endtask

   task automatic t_reg();
      do_stop(5'b10111);
      check("R4 mode", mode, 2);
      check("R4 ctl", {clk_gate, reg_keep, pwr_down}, 3'b110);
      @(negedge clk);
      irq = 4'b1000;
      @(negedge clk);
      irq = '0;
      check("R8 irq3 exit", mode, 0);
      check("R8 clocks back", clk_gate, 0);
   endtask

   task automatic t_plain();
      do_stop(5'b10100);
      check("R5 mode", mode, 3);
      check("R5 ctl", {clk_gate, reg_keep, pwr_down}, 3'b100);
      // R7: config changes while stopped have no effect
      @(negedge clk);
      set_cfg(5'b11111);
      @(negedge clk);
      check("R7 cfg ignored in stop", mode, 3);
      // R11: stop strobe ignored
      set_cfg(5'b00000);
      stop_exec = 1'b1;
      @(negedge clk);
      stop_exec = 1'b0;
      check("R11 mode kept", mode, 3);
      check("R11 no ill", ill_rst, 0);
      @(negedge clk);
      irq = 4'b0001;
      @(negedge clk);
      irq = '0;
      check("R8 irq0 exit", mode, 0);
      // R7: in run, config change without strobe
      set_cfg(5'b10001);
      @(negedge clk);
      @(negedge clk);
      check("R7 run unchanged", mode, 0);
   endtask

   task automatic t_deep();
      do_stop(5'b10011);
      check("R6 mode", mode, 4);
      check("R6 ctl", {clk_gate, pwr_down, io_hold, reg_keep}, 4'b1110);
      @(negedge clk);
      irq = '1;
      ext_wake = 1'b1;
      stop_exec = 1'b1;
      @(negedge clk);
      stop_exec = 1'b0;
      @(negedge clk);
      irq = '0;
      ext_wake = 1'b0;
      check("R9 deep ignores irq", mode, 4);
      check("R11 no ill in deep", ill_rst, 0);
      pin_n = 1'b0;
      for (int i = 0; i < SYNC; i++) begin
         @(negedge clk);
         check("R9 sync latency", mode, 4);
      end
      for (int i = 0; i < WRC; i++) begin
         @(negedge clk);
         check("R10 wake rst mode", mode, 5);
         check("R10 wake rst + hold", {wake_rst, io_hold}, 2'b11);
      end
      pin_n = 1'b1;
      @(negedge clk);
      check("R10 back to run", mode, 0);
      check("R10 hold released", {wake_rst, io_hold}, 2'b00);
      repeat (SYNC + 1) @(negedge clk);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_illegal();
      t_dbg();
      t_reg();
      t_plain();
      t_deep();
      t_deep();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule